// File: doc/BRIEF.md
# Integer Instruction Execute Unit

This block takes one 32-bit instruction word together with the values already read for its two source registers, and produces the integer result, the number of the register to write, and a write-enable flag. It decodes the three fixed instruction layouts and chooses between the register operand, a sign-extended immediate and a zero-extended immediate. It then performs one of the supported register or immediate operations, or forms a load/store effective address.

One instruction is accepted per clock when `in_valid` is high. All outputs are registered, so the answer for an instruction issued in cycle N is visible in cycle N+1. The `src_a` input carries the value of the register named by bits [25:21]. The `src_b` input carries the value of the register named by bits [20:16]. Register reads, memory access, branches and traps belong to neighbouring blocks.

Top module: `int_exec_unit`

## Requirements
- R1: For opcode 0 (bits [31:26]) the destination is bits [15:11]. For every other legal opcode it is bits [20:16]. For an illegal word it is 0.
- R2: Function 0x20 (add), function 0x22 (sub) and opcode 0x08 (add immediate) give src_a+src_b, src_a-src_b and src_a+sext(imm) modulo 2^32, with no trap. sext copies bit 15 of bits [15:0] into the upper half.
- R3: Functions 0x24, 0x25 and 0x27 give AND, OR and NOR (the complement of OR) of src_a and src_b. Opcodes 0x0C and 0x0D give AND and OR of src_a with the immediate extended with zeros.
- R4: Function 0x00 shifts src_b left and function 0x02 shifts it right by bits [10:6] (0 to 31). Vacated bits are filled with zeros.
- R5: Function 0x2A compares src_a with src_b, and opcode 0x0A compares src_a with sext(imm), both as signed values. The result is 1 when src_a is less, otherwise 0.
- R6: Opcode 0x0F places the immediate in bits [31:16] of the result and zeros in bits [15:0].
- R7: Opcodes 0x23 (load) and 0x2B (store) give the address src_a+sext(imm). For these, mem_access is 1, wr_en is 0 and the destination is bits [20:16].
- R8: An illegal opcode, or an opcode-0 word with an unlisted function code, raises illegal with wr_en=0, mem_access=0, result=0 and destination 0.
- R9: Outputs appear one clock after issue. A cycle with in_valid low yields out_valid, wr_en, mem_access and illegal all 0 in the next cycle.
- R10: While rst is high, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction present this cycle |
| instr | input | 32 | Instruction word |
| src_a | input | 32 | Value of the register named in bits [25:21] |
| src_b | input | 32 | Value of the register named in bits [20:16] |
| out_valid | output | 1 | Registered copy of in_valid |
| result | output | 32 | Computed value or effective address |
| dest_reg | output | 5 | Destination register number |
| wr_en | output | 1 | Result should be written to dest_reg |
| mem_access | output | 1 | Result is a load/store address |
| illegal | output | 1 | Instruction not recognised |

## Verification
A wrong decode shows up one clock after issue. It appears as a wrong destination field, a flipped write-enable, or a stray illegal or memory flag on the very next cycle. A wrong operand choice, such as the wrong extension or shifting the wrong source, corrupts `result` for that instruction only, because no state carries from one instruction to the next. Sweeping every opcode, every function code, and operand values at the sign and carry boundaries therefore exposes each fault within a single cycle of the instruction that triggers it.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;
  localparam int WORD_W   = 32;
  localparam int REGSEL_W = 5;
  localparam int SHAMT_W  = 5;
  localparam int IMM_W    = 16;
  localparam int CODE_W   = 6;
  localparam int HALF_W   = WORD_W / 2;

  localparam logic [CODE_W-1:0] OPC_REG   = 6'h00;
  localparam logic [CODE_W-1:0] OPC_ADDI  = 6'h08;
  localparam logic [CODE_W-1:0] OPC_SLTI  = 6'h0A;
  localparam logic [CODE_W-1:0] OPC_ANDI  = 6'h0C;
  localparam logic [CODE_W-1:0] OPC_ORI   = 6'h0D;
  localparam logic [CODE_W-1:0] OPC_LUI   = 6'h0F;
  localparam logic [CODE_W-1:0] OPC_LOAD  = 6'h23;
  localparam logic [CODE_W-1:0] OPC_STORE = 6'h2B;

  localparam logic [CODE_W-1:0] FN_SLL = 6'h00;
  localparam logic [CODE_W-1:0] FN_SRL = 6'h02;
  localparam logic [CODE_W-1:0] FN_ADD = 6'h20;
  localparam logic [CODE_W-1:0] FN_SUB = 6'h22;
  localparam logic [CODE_W-1:0] FN_AND = 6'h24;
  localparam logic [CODE_W-1:0] FN_OR  = 6'h25;
  localparam logic [CODE_W-1:0] FN_NOR = 6'h27;
  localparam logic [CODE_W-1:0] FN_SLT = 6'h2A;

  typedef enum logic [3:0] {
    K_NONE, K_ADD, K_SUB, K_AND, K_OR, K_NOR, K_SLL, K_SRL, K_SLT, K_LUI
  } op_kind_e;

  typedef enum logic [1:0] {
    SRC_REG, SRC_SEXT, SRC_ZEXT
  } bsrc_e;

  function automatic logic [WORD_W-1:0] f_sext(input logic [IMM_W-1:0] v);
    return {{(WORD_W-IMM_W){v[IMM_W-1]}}, v};
  endfunction

  function automatic logic [WORD_W-1:0] f_zext(input logic [IMM_W-1:0] v);
    return {{(WORD_W-IMM_W){1'b0}}, v};
  endfunction

  function automatic logic [WORD_W-1:0] f_alu(input op_kind_e k,
                                              input logic [WORD_W-1:0] a,
                                              input logic [WORD_W-1:0] b,
                                              input logic [SHAMT_W-1:0] sh);
    logic [WORD_W-1:0] r;
    case (k)
      K_ADD:   r = a + b;
      K_SUB:   r = a - b;
      K_AND:   r = a & b;
      K_OR:    r = a | b;
      K_NOR:   r = ~(a | b);
      K_SLL:   r = b << sh;
      K_SRL:   r = b >> sh;
      K_SLT:   r = {{(WORD_W-1){1'b0}}, ($signed(a) < $signed(b))};
      K_LUI:   r = {b[HALF_W-1:0], {HALF_W{1'b0}}};
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/int_exec_decode.sv
module int_exec_decode
  import int_exec_pkg::*;
(
  input  logic [WORD_W-1:0]   instr,
  output op_kind_e            kind,
  output bsrc_e               bsel,
  output logic [REGSEL_W-1:0] dest,
  output logic [SHAMT_W-1:0]  shamt,
  output logic [IMM_W-1:0]    imm,
  output logic                writes,
  output logic                mem,
  output logic                bad
);
  logic [CODE_W-1:0]   opc;
  logic [CODE_W-1:0]   fn;
  logic [REGSEL_W-1:0] rt_f;
  logic [REGSEL_W-1:0] rd_f;
  logic                unused_rs;

  assign opc       = instr[31:26];
  assign rt_f      = instr[20:16];
  assign rd_f      = instr[15:11];
  assign shamt     = instr[10:6];
  assign fn        = instr[5:0];
  assign imm       = instr[15:0];
  assign unused_rs = ^instr[25:21];

  always_comb begin
    kind   = K_NONE;
    bsel   = SRC_REG;
    writes = 1'b0;
    mem    = 1'b0;
    bad    = 1'b0;
    dest   = rt_f;
    case (opc)
      OPC_REG: begin
        dest   = rd_f;
        writes = 1'b1;
        case (fn)
          FN_ADD:  kind = K_ADD;
          FN_SUB:  kind = K_SUB;
          FN_AND:  kind = K_AND;
          FN_OR:   kind = K_OR;
          FN_NOR:  kind = K_NOR;
          FN_SLL:  kind = K_SLL;
          FN_SRL:  kind = K_SRL;
          FN_SLT:  kind = K_SLT;
          default: bad  = 1'b1;
        endcase
      end
      OPC_ADDI:  begin kind = K_ADD; bsel = SRC_SEXT; writes = 1'b1; end
      OPC_SLTI:  begin kind = K_SLT; bsel = SRC_SEXT; writes = 1'b1; end
      OPC_ANDI:  begin kind = K_AND; bsel = SRC_ZEXT; writes = 1'b1; end
      OPC_ORI:   begin kind = K_OR;  bsel = SRC_ZEXT; writes = 1'b1; end
      OPC_LUI:   begin kind = K_LUI; bsel = SRC_ZEXT; writes = 1'b1; end
      OPC_LOAD,
      OPC_STORE: begin kind = K_ADD; bsel = SRC_SEXT; mem = 1'b1; end
      default:   bad = 1'b1;
    endcase
    if (bad) begin
      kind   = K_NONE;
      writes = 1'b0;
      mem    = 1'b0;
      dest   = '0;
    end
  end
endmodule

// File: rtl/int_exec_opsel.sv
module int_exec_opsel
  import int_exec_pkg::*;
(
  input  bsrc_e             bsel,
  input  logic [WORD_W-1:0] reg_b,
  input  logic [IMM_W-1:0]  imm,
  output logic [WORD_W-1:0] b_eff
);
  always_comb begin
    case (bsel)
      SRC_SEXT: b_eff = f_sext(imm);
      SRC_ZEXT: b_eff = f_zext(imm);
      default:  b_eff = reg_b;
    endcase
  end
endmodule

// File: rtl/int_exec_alu.sv
module int_exec_alu
  import int_exec_pkg::*;
(
  input  op_kind_e           kind,
  input  logic [WORD_W-1:0]  a,
  input  logic [WORD_W-1:0]  b,
  input  logic [SHAMT_W-1:0] shamt,
  output logic [WORD_W-1:0]  y
);
  assign y = f_alu(kind, a, b, shamt);
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import int_exec_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [WORD_W-1:0]   instr,
  input  logic [WORD_W-1:0]   src_a,
  input  logic [WORD_W-1:0]   src_b,
  output logic                out_valid,
  output logic [WORD_W-1:0]   result,
  output logic [REGSEL_W-1:0] dest_reg,
  output logic                wr_en,
  output logic                mem_access,
  output logic                illegal
);
  op_kind_e            dec_kind;
  bsrc_e               dec_bsel;
  logic [REGSEL_W-1:0] dec_dest;
  logic [SHAMT_W-1:0]  dec_shamt;
  logic [IMM_W-1:0]    dec_imm;
  logic                dec_writes;
  logic                dec_mem;
  logic                dec_bad;
  logic [WORD_W-1:0]   b_eff;
  logic [WORD_W-1:0]   alu_y;

  int_exec_decode u_dec (
    .instr(instr), .kind(dec_kind), .bsel(dec_bsel), .dest(dec_dest),
    .shamt(dec_shamt), .imm(dec_imm), .writes(dec_writes),
    .mem(dec_mem), .bad(dec_bad)
  );

  int_exec_opsel u_sel (
    .bsel(dec_bsel), .reg_b(src_b), .imm(dec_imm), .b_eff(b_eff)
  );

  int_exec_alu u_alu (
    .kind(dec_kind), .a(src_a), .b(b_eff), .shamt(dec_shamt), .y(alu_y)
  );

  always_ff @(posedge clk) begin
    if (rst || !in_valid) begin
      out_valid  <= 1'b0;
      result     <= '0;
      dest_reg   <= '0;
      wr_en      <= 1'b0;
      mem_access <= 1'b0;
      illegal    <= 1'b0;
    end else begin
      out_valid  <= 1'b1;
      result     <= alu_y;
      dest_reg   <= dec_dest;
      wr_en      <= dec_writes;
      mem_access <= dec_mem;
      illegal    <= dec_bad;
    end
  end
endmodule

// File: rtl/int_exec_checker.sv
module int_exec_checker
  import int_exec_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input op_kind_e            dec_kind,
  input logic                dec_mem,
  input logic                out_valid,
  input logic [WORD_W-1:0]   result,
  input logic [REGSEL_W-1:0] dest_reg,
  input logic                wr_en,
  input logic                mem_access,
  input logic                illegal
);
  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_en, mem_access, illegal}));

  assert_illegal_zero_R8: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (result == '0 && dest_reg == '0));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!wr_en && !mem_access && !illegal));

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  assert_compare_bit_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dec_kind == K_SLT) |=> (result[WORD_W-1:1] == '0));

  assert_upper_low_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dec_kind == K_LUI) |=> (result[HALF_W-1:0] == '0));

  assert_mem_no_write_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dec_mem) |=> (mem_access && !wr_en));
endmodule

bind int_exec_unit int_exec_checker u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .dec_kind(dec_kind),
  .dec_mem(dec_mem), .out_valid(out_valid), .result(result),
  .dest_reg(dest_reg), .wr_en(wr_en), .mem_access(mem_access),
  .illegal(illegal)
);

// File: tb/int_exec_unit_test.sv
module int_exec_unit_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] instr, src_a, src_b;
  logic        out_valid, wr_en, mem_access, illegal;
  logic [31:0] result;
  logic [4:0]  dest_reg;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_exec_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .result(result),
    .dest_reg(dest_reg), .wr_en(wr_en), .mem_access(mem_access),
    .illegal(illegal)
  );

  logic [31:0] vals [8];

  task automatic check32(input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // Independent reference built from the requirement text.
  task automatic model(input logic [31:0] w, input logic [31:0] a,
                       input logic [31:0] b, output logic [31:0] res,
                       output logic [4:0] dst, output logic we,
                       output logic mem, output logic ill, output string tag);
    logic [5:0]  op;
    logic [5:0]  fc;
    logic [31:0] se, ze;
    op  = w[31:26];
    fc  = w[5:0];
    se  = 32'($signed(w[15:0]));
    ze  = 32'(w[15:0]);
    res = 0; dst = w[20:16]; we = 1; mem = 0; ill = 0; tag = "R1";
    if (op == 6'd0) begin
      dst = w[15:11];
      if      (fc == 6'h20) begin res = a + b;    tag = "R2"; end
      else if (fc == 6'h22) begin res = a + (~b + 1); tag = "R2"; end
      else if (fc == 6'h24) begin res = a & b;    tag = "R3"; end
      else if (fc == 6'h25) begin res = a | b;    tag = "R3"; end
      else if (fc == 6'h27) begin res = ~a & ~b;  tag = "R3"; end
      else if (fc == 6'h00) begin res = b * (33'd1 << w[10:6]); tag = "R4"; end
      else if (fc == 6'h02) begin res = b / (33'd1 << w[10:6]); tag = "R4"; end
      else if (fc == 6'h2A) begin
        res = ((a ^ 32'h8000_0000) < (b ^ 32'h8000_0000)) ? 1 : 0; tag = "R5";
      end else begin we = 0; ill = 1; dst = 0; tag = "R8"; end
    end
    else if (op == 6'h08) begin res = a + se; tag = "R2"; end
    else if (op == 6'h0A) begin
      res = ((a ^ 32'h8000_0000) < (se ^ 32'h8000_0000)) ? 1 : 0; tag = "R5";
    end
    else if (op == 6'h0C) begin res = a & ze; tag = "R3"; end
    else if (op == 6'h0D) begin res = a | ze; tag = "R3"; end
    else if (op == 6'h0F) begin res = ze * 32'h1_0000; tag = "R6"; end
    else if (op == 6'h23 || op == 6'h2B) begin
      res = a + se; we = 0; mem = 1; tag = "R7";
    end
    else begin we = 0; ill = 1; dst = 0; tag = "R8"; end
  endtask

  // Drive on a falling edge, check on the next falling edge (one register).
  task automatic issue_and_check(input logic [31:0] w, input logic [31:0] a,
                                 input logic [31:0] b);
    logic [31:0] er; logic [4:0] ed; logic ewe, emem, eill; string tag;
    model(w, a, b, er, ed, ewe, emem, eill, tag);
    in_valid = 1; instr = w; src_a = a; src_b = b;
    @(negedge clk);
    check32("R9", "out_valid", 32'(out_valid), 32'd1);
    check32(tag, "result", result, er);
    check32("R1", "dest_reg", 32'(dest_reg), 32'(ed));
    check32(tag, "wr_en", 32'(wr_en), 32'(ewe));
    check32(eill ? "R8" : "R7", "mem_access", 32'(mem_access), 32'(emem));
    check32("R8", "illegal", 32'(illegal), 32'(eill));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001;
    vals[2] = 32'hFFFF_FFFF; vals[3] = 32'h7FFF_FFFF;
    vals[4] = 32'h8000_0000; vals[5] = 32'h1234_8765;
    vals[6] = 32'hFFFF_8000; vals[7] = 32'h0000_7FFF;

    rst = 1; in_valid = 1; instr = {6'd0, 5'd1, 5'd2, 5'd3, 5'd0, 6'h20};
    src_a = 32'h5; src_b = 32'h7;
    repeat (3) @(negedge clk);
    // R10: reset forces every output low even with an instruction present.
    check32("R10", "out_valid", 32'(out_valid), 0);
    check32("R10", "result", result, 0);
    check32("R10", "dest_reg", 32'(dest_reg), 0);
    check32("R10", "flags", 32'({wr_en, mem_access, illegal}), 0);
    rst = 0; in_valid = 0;
    @(negedge clk);
    // R9: idle cycle gives quiet outputs.
    check32("R9", "idle out_valid", 32'(out_valid), 0);
    check32("R9", "idle wr_en", 32'(wr_en), 0);

    begin
      logic [5:0] fns [8];
      logic [5:0] ops [7];
      fns = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h27, 6'h00, 6'h02, 6'h2A};
      ops = '{6'h08, 6'h0A, 6'h0C, 6'h0D, 6'h0F, 6'h23, 6'h2B};
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          logic [4:0]  rs_f, rt_f, rd_f, sh;
          logic [15:0] im;
          rs_f = 5'((i * 5 + j) & 31);
          rt_f = 5'((i + j * 7) & 31);
          rd_f = 5'((i * 3 + j) & 31);
          sh   = 5'((i * 4 + j) & 31);
          im   = vals[j][15:0] ^ 16'(i * 16'h1111);
          for (int f = 0; f < 8; f++)
            issue_and_check({6'd0, rs_f, rt_f, rd_f, sh, fns[f]}, vals[i], vals[j]);
          for (int o = 0; o < 7; o++)
            issue_and_check({ops[o], rs_f, rt_f, im}, vals[i], vals[j]);
        end
      end
    end

    // R8: full opcode sweep and full function-code sweep.
    for (int o = 0; o < 64; o++)
      issue_and_check({6'(o), 5'd4, 5'd9, 16'hA5C3}, 32'h89AB_CDEF, 32'h0F0F_0F0F);
    for (int f = 0; f < 64; f++)
      issue_and_check({6'd0, 5'd4, 5'd9, 5'd17, 5'd3, 6'(f)}, 32'h89AB_CDEF, 32'hF0F0_0F0F);

    // R6 then R3: upper-half load followed by low-half OR builds a constant.
    issue_and_check({6'h0F, 5'd0, 5'd8, 16'hDEAD}, 32'h0, 32'h0);
    issue_and_check({6'h0D, 5'd8, 5'd8, 16'hBEEF}, 32'hDEAD_0000, 32'h0);

    // R9: dropping in_valid after a legal instruction quiets the outputs.
    in_valid = 0;
    @(negedge clk);
    check32("R9", "drop out_valid", 32'(out_valid), 0);
    check32("R9", "drop flags", 32'({wr_en, mem_access, illegal}), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule